// File: doc/BRIEF.md
# PC-Tagged Access History Set

This block records recent demand data accesses for prefetch logic. It holds one untagged global history and a small set of local histories, each owned by the program counter that issued the accesses. Each history stores records in arrival order. A record holds the line address, the cache level of the access (L1 or L2) and the hit/miss flag of that access. In each cycle, up to four L1 demand accesses and one L2 demand access may arrive. Each one is offered to the global history and, independently, to the local history that owns its program counter.

For every access and every history, the block reports whether the history gained new information. New information means a record was appended, or an existing record was promoted from L1 to L2. Downstream pattern logic uses this report to decide whether to run. Local histories are claimed by program counters with least-recently-used replacement. A history that is reclaimed is emptied before it takes its first record. A combinational lookup port tells whether a line address is currently held in the global history or in any local history.

Top module: `ahb_history_set`

## Requirements
- R1: After reset, every history is empty and every local history is untagged. A lookup finds nothing, and the first access from any program counter reports a tag miss.
- R2: An address not held in a history is appended as the newest record, and its report bit is 1. From the next cycle, a lookup returns the record with its level (lk_glb_l1 = 1 for an L1 access, 0 for an L2 access) and its hit flag.
- R3: An address already held is never appended again. If the incoming access is L2 and the stored record is L1, the stored level becomes L2, the hit flag is kept and the report bit is 1. In every other case the report bit is 0 and the history is unchanged.
- R4: A history that is full (GLB_DEPTH = 64 records for the global history, LOC_DEPTH for each local one) drops its oldest record before it appends a new one.
- R5: Accesses in one cycle are applied in the order L1 slot 0, 1, 2, 3, then L2. Each access sees the effect of every earlier access in that cycle. Report bit k belongs to L1 slot k, and bit 4 belongs to the L2 slot.
- R6: An access whose program counter tags a local history reports a tag hit (loc_tag_hit = 1). Otherwise it claims a history: the lowest-numbered untagged history if one exists, or else the least recently used one. The claimed history is emptied, retagged and reports a tag miss.
- R7: The local history that receives an access becomes the most recently used.
- R8: Local histories follow the same append, duplicate and eviction rules as the global history, with their own contents. loc_new reports the result.
- R9: The lookup port reflects registered contents only. lk_loc_found, lk_loc_l1 and lk_loc_dhit are ORed over all local histories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1_vld | input | L1_SLOTS | Valid per L1 demand slot |
| l1_pc | input | L1_SLOTS*PCW | Program counter per L1 slot, slot 0 in the low bits |
| l1_addr | input | L1_SLOTS*AW | Line address per L1 slot |
| l1_hit | input | L1_SLOTS | Hit flag per L1 slot |
| l2_vld | input | 1 | Valid of the L2 demand slot |
| l2_pc | input | PCW | Program counter of the L2 access |
| l2_addr | input | AW | Line address of the L2 access |
| l2_hit | input | 1 | Hit flag of the L2 access |
| glb_new | output | L1_SLOTS+1 | Global history gained information, per slot |
| loc_new | output | L1_SLOTS+1 | Local history gained information, per slot |
| loc_tag_hit | output | L1_SLOTS+1 | Program counter was already tagged, per slot |
| lk_addr | input | AW | Lookup line address |
| lk_glb_found | output | 1 | Address held in the global history |
| lk_glb_l1 | output | 1 | Level of the global record, 1 = L1 |
| lk_glb_dhit | output | 1 | Hit flag of the global record |
| lk_loc_found | output | 1 | Address held in some local history |
| lk_loc_l1 | output | 1 | Some local record of the address is at L1 |
| lk_loc_dhit | output | 1 | Some local record of the address has its hit flag set |

## Verification
The assertions are checked on every cycle. They cover these invariants: a history never holds two records of one address, its fill never exceeds its depth and never falls without a clear, tags stay unique, the recency ranks stay a permutation, and every valid access lands in exactly one local history. Other behaviour can only be shown by the bench's scenarios: which record is evicted, the promotion of a record from L1 to L2, the ordering of slots within a cycle, the choice of victim under LRU, and the clearing of a reclaimed history. The bench shows these by comparing the reports and lookups against an independent model.

// File: rtl/ahb_pkg.sv
package ahb_pkg;
    typedef enum logic {
        LVL_L2 = 1'b0,
        LVL_L1 = 1'b1
    } lvl_e;
endpackage

// File: rtl/ahb_hist_buf.sv
module ahb_hist_buf #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 26,
    parameter int unsigned NS    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NS-1:0]     slot_en,
    input  logic [NS-1:0]     slot_clr,
    input  logic [NS*AW-1:0]  slot_addr,
    input  logic [NS-1:0]     slot_l1,
    input  logic [NS-1:0]     slot_dhit,
    output logic [NS-1:0]     slot_new,
    input  logic [AW-1:0]     lk_addr,
    output logic              lk_found,
    output logic              lk_l1,
    output logic              lk_dhit
);
    import ahb_pkg::*;

    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        lvl_e          lvl;
        logic          dhit;
    } rec_t;

    typedef struct packed {
        rec_t [DEPTH-1:0] ent;
        logic [CW-1:0]    cnt;
    } st_t;

    st_t st_d, st_q;

    // Sequential application of the slots, oldest record at index 0
    always_comb begin
        logic mt;
        st_d     = st_q;
        slot_new = '0;
        for (int s = 0; s < NS; s++) begin
            mt = 1'b0;
            if (slot_clr[s]) begin
                st_d.cnt = '0;
            end
            if (slot_en[s]) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) < st_d.cnt && st_d.ent[i].addr == slot_addr[s*AW +: AW]) begin
                        mt = 1'b1;
                        if (!slot_l1[s] && st_d.ent[i].lvl == LVL_L1) begin
                            st_d.ent[i].lvl = LVL_L2;
                            slot_new[s]     = 1'b1;
                        end
                    end
                end
                if (!mt) begin
                    if (st_d.cnt == CW'(DEPTH)) begin
                        for (int i = 0; i < DEPTH - 1; i++) begin
                            st_d.ent[i] = st_d.ent[i+1];
                        end
                        st_d.cnt = st_d.cnt - CW'(1);
                    end
                    for (int i = 0; i < DEPTH; i++) begin
                        if (CW'(i) == st_d.cnt) begin
                            st_d.ent[i].addr = slot_addr[s*AW +: AW];
                            st_d.ent[i].lvl  = slot_l1[s] ? LVL_L1 : LVL_L2;
                            st_d.ent[i].dhit = slot_dhit[s];
                        end
                    end
                    st_d.cnt    = st_d.cnt + CW'(1);
                    slot_new[s] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Lookup from registered contents only
    always_comb begin
        lk_found = 1'b0;
        lk_l1    = 1'b0;
        lk_dhit  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < st_q.cnt && st_q.ent[i].addr == lk_addr) begin
                lk_found = 1'b1;
                lk_l1    = (st_q.ent[i].lvl == LVL_L1);
                lk_dhit  = st_q.ent[i].dhit;
            end
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R4

    AST_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        !(|slot_clr) |=> st_q.cnt >= $past(st_q.cnt)); // R4

    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int j = i + 1; j < DEPTH; j++) begin
                    if (CW'(j) < st_q.cnt) begin
                        AST_NO_DUP_ADDR: assert (st_q.ent[i].addr != st_q.ent[j].addr); // R3
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ahb_pc_dir.sv
module ahb_pc_dir #(
    parameter int unsigned NLOC = 4,
    parameter int unsigned PCW  = 16,
    parameter int unsigned NS   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NS-1:0]      vld,
    input  logic [NS*PCW-1:0]  pc,
    output logic [NLOC*NS-1:0] buf_en,
    output logic [NLOC*NS-1:0] buf_clr,
    output logic [NS-1:0]      tag_hit
);
    localparam int unsigned AGW = (NLOC > 1) ? $clog2(NLOC) : 1;

    typedef struct packed {
        logic [PCW-1:0] tag;
        logic           tv;
        logic [AGW-1:0] age;
    } way_t;

    way_t [NLOC-1:0] dir_d, dir_q;

    always_comb begin
        logic [NLOC-1:0] pick;
        logic            got;
        logic [AGW-1:0]  tgt_age;
        dir_d   = dir_q;
        buf_en  = '0;
        buf_clr = '0;
        tag_hit = '0;
        for (int s = 0; s < NS; s++) begin
            pick    = '0;
            got     = 1'b0;
            tgt_age = '0;
            if (vld[s]) begin
                for (int b = 0; b < NLOC; b++) begin
                    if (dir_d[b].tv && dir_d[b].tag == pc[s*PCW +: PCW]) begin
                        pick[b] = 1'b1;
                    end
                end
                if (|pick) begin
                    tag_hit[s] = 1'b1;
                end else begin
                    for (int b = 0; b < NLOC; b++) begin
                        if (!got && !dir_d[b].tv) begin
                            pick[b] = 1'b1;
                            got     = 1'b1;
                        end
                    end
                    if (!got) begin
                        for (int b = 0; b < NLOC; b++) begin
                            if (dir_d[b].age == AGW'(NLOC - 1)) begin
                                pick[b] = 1'b1;
                            end
                        end
                    end
                    for (int b = 0; b < NLOC; b++) begin
                        if (pick[b]) begin
                            dir_d[b].tag      = pc[s*PCW +: PCW];
                            dir_d[b].tv       = 1'b1;
                            buf_clr[b*NS + s] = 1'b1;
                        end
                    end
                end
                for (int b = 0; b < NLOC; b++) begin
                    if (pick[b]) begin
                        tgt_age = dir_d[b].age;
                    end
                end
                for (int b = 0; b < NLOC; b++) begin
                    buf_en[b*NS + s] = pick[b];
                    if (pick[b]) begin
                        dir_d[b].age = '0;
                    end else if (dir_d[b].age < tgt_age) begin
                        dir_d[b].age = dir_d[b].age + AGW'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NLOC; b++) begin
                dir_q[b].tag <= '0;
                dir_q[b].tv  <= 1'b0;
                dir_q[b].age <= AGW'(b);
            end
        end else begin
            dir_q <= dir_d;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NLOC; i++) begin
                for (int j = i + 1; j < NLOC; j++) begin
                    AST_TAG_UNIQUE: assert (!(dir_q[i].tv && dir_q[j].tv &&
                                              dir_q[i].tag == dir_q[j].tag)); // R6
                    AST_AGE_PERM: assert (dir_q[i].age != dir_q[j].age); // R7
                end
            end
        end
    end
endmodule

// File: rtl/ahb_history_set.sv
module ahb_history_set #(
    parameter int unsigned L1_SLOTS  = 4,
    parameter int unsigned NLOC      = 4,
    parameter int unsigned LOC_DEPTH = 16,
    parameter int unsigned GLB_DEPTH = 64,
    parameter int unsigned AW        = 26,
    parameter int unsigned PCW       = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [L1_SLOTS-1:0]     l1_vld,
    input  logic [L1_SLOTS*PCW-1:0] l1_pc,
    input  logic [L1_SLOTS*AW-1:0]  l1_addr,
    input  logic [L1_SLOTS-1:0]     l1_hit,
    input  logic                    l2_vld,
    input  logic [PCW-1:0]          l2_pc,
    input  logic [AW-1:0]           l2_addr,
    input  logic                    l2_hit,
    output logic [L1_SLOTS:0]       glb_new,
    output logic [L1_SLOTS:0]       loc_new,
    output logic [L1_SLOTS:0]       loc_tag_hit,
    input  logic [AW-1:0]           lk_addr,
    output logic                    lk_glb_found,
    output logic                    lk_glb_l1,
    output logic                    lk_glb_dhit,
    output logic                    lk_loc_found,
    output logic                    lk_loc_l1,
    output logic                    lk_loc_dhit
);
    localparam int unsigned NS = L1_SLOTS + 1;

    logic [NS-1:0]      all_vld;
    logic [NS*PCW-1:0]  all_pc;
    logic [NS*AW-1:0]   all_addr;
    logic [NS-1:0]      all_l1;
    logic [NS-1:0]      all_dhit;
    logic [NLOC*NS-1:0] buf_en;
    logic [NLOC*NS-1:0] buf_clr;
    logic [NLOC-1:0][NS-1:0] loc_new_b;
    logic [NLOC-1:0]    loc_found_b;
    logic [NLOC-1:0]    loc_l1_b;
    logic [NLOC-1:0]    loc_dhit_b;

    // Slot order: L1 slots in the low positions, the L2 slot last
    assign all_vld  = {l2_vld, l1_vld};
    assign all_pc   = {l2_pc, l1_pc};
    assign all_addr = {l2_addr, l1_addr};
    assign all_l1   = {1'b0, {L1_SLOTS{1'b1}}};
    assign all_dhit = {l2_hit, l1_hit};

    ahb_hist_buf #(.DEPTH(GLB_DEPTH), .AW(AW), .NS(NS)) u_glb (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_en  (all_vld),
        .slot_clr ('0),
        .slot_addr(all_addr),
        .slot_l1  (all_l1),
        .slot_dhit(all_dhit),
        .slot_new (glb_new),
        .lk_addr  (lk_addr),
        .lk_found (lk_glb_found),
        .lk_l1    (lk_glb_l1),
        .lk_dhit  (lk_glb_dhit)
    );

    ahb_pc_dir #(.NLOC(NLOC), .PCW(PCW), .NS(NS)) u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld    (all_vld),
        .pc     (all_pc),
        .buf_en (buf_en),
        .buf_clr(buf_clr),
        .tag_hit(loc_tag_hit)
    );

    for (genvar b = 0; b < NLOC; b++) begin : g_loc
        ahb_hist_buf #(.DEPTH(LOC_DEPTH), .AW(AW), .NS(NS)) u_loc (
            .clk      (clk),
            .rst_n    (rst_n),
            .slot_en  (buf_en[b*NS +: NS]),
            .slot_clr (buf_clr[b*NS +: NS]),
            .slot_addr(all_addr),
            .slot_l1  (all_l1),
            .slot_dhit(all_dhit),
            .slot_new (loc_new_b[b]),
            .lk_addr  (lk_addr),
            .lk_found (loc_found_b[b]),
            .lk_l1    (loc_l1_b[b]),
            .lk_dhit  (loc_dhit_b[b])
        );
    end

    always_comb begin
        loc_new      = '0;
        lk_loc_found = 1'b0;
        lk_loc_l1    = 1'b0;
        lk_loc_dhit  = 1'b0;
        for (int b = 0; b < NLOC; b++) begin
            loc_new      = loc_new | loc_new_b[b];
            lk_loc_found = lk_loc_found | loc_found_b[b];
            lk_loc_l1    = lk_loc_l1 | (loc_found_b[b] & loc_l1_b[b]);
            lk_loc_dhit  = lk_loc_dhit | (loc_found_b[b] & loc_dhit_b[b]);
        end
    end

    for (genvar s = 0; s < NS; s++) begin : g_chk
        logic [NLOC-1:0] col;
        for (genvar b = 0; b < NLOC; b++) begin : g_col
            assign col[b] = buf_en[b*NS + s];
        end
        AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
            all_vld[s] |-> $countones(col) == 1); // R6
        AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !all_vld[s] |-> !(glb_new[s] || loc_new[s] || loc_tag_hit[s])); // R5
    end
endmodule

// File: tb/ahb_history_set_test.sv
module ahb_history_set_test;
    localparam int NL = 4;
    localparam int NS = 5;
    localparam int LD = 16;
    localparam int GD = 64;
    localparam int AW = 26;
    localparam int PW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NL-1:0]    l1_vld;
    logic [NL*PW-1:0] l1_pc;
    logic [NL*AW-1:0] l1_addr;
    logic [NL-1:0]    l1_hit;
    logic             l2_vld;
    logic [PW-1:0]    l2_pc;
    logic [AW-1:0]    l2_addr;
    logic             l2_hit;
    logic [NS-1:0]    glb_new, loc_new, loc_tag_hit;
    logic [AW-1:0]    lk_addr;
    logic lk_glb_found, lk_glb_l1, lk_glb_dhit, lk_loc_found, lk_loc_l1, lk_loc_dhit;

    always #10 clk = ~clk;

    ahb_history_set uut (
        .clk(clk), .rst_n(rst_n),
        .l1_vld(l1_vld), .l1_pc(l1_pc), .l1_addr(l1_addr), .l1_hit(l1_hit),
        .l2_vld(l2_vld), .l2_pc(l2_pc), .l2_addr(l2_addr), .l2_hit(l2_hit),
        .glb_new(glb_new), .loc_new(loc_new), .loc_tag_hit(loc_tag_hit),
        .lk_addr(lk_addr),
        .lk_glb_found(lk_glb_found), .lk_glb_l1(lk_glb_l1), .lk_glb_dhit(lk_glb_dhit),
        .lk_loc_found(lk_loc_found), .lk_loc_l1(lk_loc_l1), .lk_loc_dhit(lk_loc_dhit)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Model: histories 0..3 local, 4 global
    logic [AW-1:0] m_a [5][GD];
    bit            m_l1[5][GD];
    bit            m_h [5][GD];
    int            m_cnt[5];
    logic [PW-1:0] m_tag[NL];
    bit            m_tv [NL];
    int            m_age[NL];

    // Stimulus for one cycle
    bit [NS-1:0]   s_v;
    logic [PW-1:0] s_pc[NS];
    logic [AW-1:0] s_a [NS];
    bit            s_h [NS];
    logic [AW-1:0] s_lk;

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int depth_of(input int b);
        return (b == 4) ? GD : LD;
    endfunction

    task automatic m_ins(input int b, input logic [AW-1:0] a, input bit l1, input bit h,
                         output bit nw);
        nw = 1'b0;
        for (int i = 0; i < m_cnt[b]; i++) begin
            if (m_a[b][i] == a) begin
                if (!l1 && m_l1[b][i]) begin
                    m_l1[b][i] = 1'b0;
                    nw = 1'b1;
                end
                return;
            end
        end
        if (m_cnt[b] == depth_of(b)) begin
            for (int i = 0; i < depth_of(b) - 1; i++) begin
                m_a[b][i]  = m_a[b][i+1];
                m_l1[b][i] = m_l1[b][i+1];
                m_h[b][i]  = m_h[b][i+1];
            end
            m_cnt[b]--;
        end
        m_a[b][m_cnt[b]]  = a;
        m_l1[b][m_cnt[b]] = l1;
        m_h[b][m_cnt[b]]  = h;
        m_cnt[b]++;
        nw = 1'b1;
    endtask

    task automatic m_local(input logic [PW-1:0] pc, input logic [AW-1:0] a, input bit l1,
                           input bit h, output bit th, output bit nw);
        int tgt = -1;
        int ta;
        for (int b = 0; b < NL; b++) if (m_tv[b] && m_tag[b] == pc) tgt = b;
        th = (tgt >= 0);
        if (tgt < 0) begin
            for (int b = NL - 1; b >= 0; b--) if (!m_tv[b]) tgt = b;
            if (tgt < 0) for (int b = 0; b < NL; b++) if (m_age[b] == NL - 1) tgt = b;
            m_tag[tgt] = pc;
            m_tv[tgt]  = 1'b1;
            m_cnt[tgt] = 0;
        end
        ta = m_age[tgt];
        for (int b = 0; b < NL; b++) if (m_age[b] < ta) m_age[b]++;
        m_age[tgt] = 0;
        m_ins(tgt, a, l1, h, nw);
    endtask

    task automatic idle();
        s_v = '0;
        for (int s = 0; s < NS; s++) begin
            s_pc[s] = '0; s_a[s] = '0; s_h[s] = 1'b0;
        end
    endtask

    // Drive one cycle, compare against the model, update the model
    task automatic step();
        bit ef, el1, eh, lf, ll1, lh, th, nw;
        bit [NS-1:0] eg, el, et;
        @(negedge clk);
        l1_vld = s_v[3:0];
        l2_vld = s_v[4];
        for (int s = 0; s < NL; s++) begin
            l1_pc[s*PW +: PW]   = s_pc[s];
            l1_addr[s*AW +: AW] = s_a[s];
            l1_hit[s]           = s_h[s];
        end
        l2_pc = s_pc[4]; l2_addr = s_a[4]; l2_hit = s_h[4];
        lk_addr = s_lk;
        ef = 0; el1 = 0; eh = 0; lf = 0; ll1 = 0; lh = 0;
        for (int i = 0; i < m_cnt[4]; i++)
            if (m_a[4][i] == s_lk) begin ef = 1; el1 = m_l1[4][i]; eh = m_h[4][i]; end
        for (int b = 0; b < NL; b++)
            for (int i = 0; i < m_cnt[b]; i++)
                if (m_a[b][i] == s_lk) begin lf = 1; ll1 |= m_l1[b][i]; lh |= m_h[b][i]; end
        eg = '0; el = '0; et = '0;
        for (int s = 0; s < NS; s++) begin
            if (s_v[s]) begin
                m_ins(4, s_a[s], s < NL, s_h[s], nw);
                eg[s] = nw;
                m_local(s_pc[s], s_a[s], s < NL, s_h[s], th, nw);
                el[s] = nw;
                et[s] = th;
            end
        end
        #5;
        check("R3 global insert report", glb_new, eg);
        check("R8 local insert report", loc_new, el);
        check("R6 tag hit report", loc_tag_hit, et);
        check("R9 lookup global", {lk_glb_found, lk_glb_l1, lk_glb_dhit}, {ef, el1, eh});
        check("R9 lookup local", {lk_loc_found, lk_loc_l1, lk_loc_dhit}, {lf, ll1, lh});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd9137));
        for (int b = 0; b < 5; b++) m_cnt[b] = 0;
        for (int b = 0; b < NL; b++) begin m_tv[b] = 0; m_tag[b] = '0; m_age[b] = b; end
        idle(); s_lk = '0;
        l1_vld = '0; l2_vld = 1'b0; l1_pc = '0; l1_addr = '0; l1_hit = '0;
        l2_pc = '0; l2_addr = '0; l2_hit = 1'b0; lk_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        idle(); s_lk = 26'h10; step();
        check("R1 reset lookup", {lk_glb_found, lk_loc_found}, 0);
        check("R1 reset reports", {glb_new, loc_new, loc_tag_hit}, 0);

        // R2: first access appended; R1 first PC is a tag miss
        idle(); s_v = 5'b00001; s_pc[0] = 16'h1; s_a[0] = 26'h10; s_h[0] = 1; step();
        check("R2 append report", glb_new[0], 1);
        check("R1 first pc tag miss", loc_tag_hit[0], 0);
        idle(); s_lk = 26'h10; step();
        check("R2 lookup level and hit", {lk_glb_found, lk_glb_l1, lk_glb_dhit}, 3'b111);

        // R3: duplicate L1 ignored, L2 upgrades and keeps hit flag
        idle(); s_v = 5'b00010; s_pc[1] = 16'h1; s_a[1] = 26'h10; s_lk = 26'h10; step();
        check("R3 dup L1 report", {glb_new[1], loc_new[1]}, 0);
        check("R6 same pc tag hit", loc_tag_hit[1], 1);
        idle(); s_v = 5'b10000; s_pc[4] = 16'h1; s_a[4] = 26'h10; s_h[4] = 0; step();
        check("R3 upgrade report", {glb_new[4], loc_new[4]}, 2'b11);
        idle(); s_lk = 26'h10; step();
        check("R3 upgraded level", {lk_glb_found, lk_glb_l1, lk_glb_dhit}, 3'b101);
        idle(); s_v = 5'b10000; s_pc[4] = 16'h1; s_a[4] = 26'h10; step();
        check("R3 dup L2 report", glb_new[4], 0);

        // R5: same-cycle ordering
        idle(); s_v = 5'b11101;
        for (int s = 0; s < NS; s++) s_pc[s] = 16'h2;
        s_a[0] = 26'h20; s_a[2] = 26'h20; s_a[3] = 26'h30; s_a[4] = 26'h30; step();
        check("R5 slot order global", glb_new, 5'b11001);
        check("R5 slot order tag", loc_tag_hit, 5'b11100);

        // R4: overflow the global history
        for (int k = 0; k < 70; k++) begin
            idle(); s_v = 5'b00001; s_pc[0] = 16'h7; s_a[0] = 26'h1000 + k; step();
        end
        idle(); s_lk = 26'h10; step();
        check("R4 oldest evicted", lk_glb_found, 0);
        idle(); s_lk = 26'h1000 + 69; step();
        check("R4 newest kept", lk_glb_found, 1);

        // R6/R7: LRU among tags 1,2,7 plus new ones
        idle(); s_v = 5'b00001; s_pc[0] = 16'h8; s_a[0] = 26'h40; step();
        idle(); s_v = 5'b00001; s_pc[0] = 16'h1; s_a[0] = 26'h41; step();
        check("R7 touched pc hit", loc_tag_hit[0], 1);
        idle(); s_v = 5'b00001; s_pc[0] = 16'h9; s_a[0] = 26'h42; step();
        check("R6 new pc claims lru", loc_tag_hit[0], 0);
        idle(); s_v = 5'b00001; s_pc[0] = 16'h1; s_a[0] = 26'h10; step();
        check("R7 mru survives", {loc_tag_hit[0], loc_new[0]}, 2'b10);
        idle(); s_v = 5'b00001; s_pc[0] = 16'h2; s_a[0] = 26'h20; step();
        check("R6 evicted pc cleared", {loc_tag_hit[0], loc_new[0]}, 2'b01);

        // Random traffic
        for (int k = 0; k < 3000; k++) begin
            idle();
            s_v = 5'($urandom_range(0, 31));
            for (int s = 0; s < NS; s++) begin
                s_pc[s] = 16'($urandom_range(0, 5));
                s_a[s]  = 26'h200 + 26'($urandom_range(0, 47));
                s_h[s]  = 1'($urandom_range(0, 1));
            end
            s_lk = 26'h200 + 26'($urandom_range(0, 47));
            step();
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule